// File: doc/BRIEF.md
# Nested Priority Interrupt Collector

This block gathers up to 128 interrupt sources for one processor core and turns them into two requests: a vectored normal request (`irq_req`) that goes through priority arbitration and nesting, and a fast request (`fiq_req`) that is a plain OR of the sources steered to it and carries no vector. Each source owns one control register that enables it, sets one of four priority levels, holds a software trigger and can steer the source to the fast line.

Software services the normal line by reading the vector register. That read returns the winning source and its level, and it pushes the level onto a small stack of active levels. While a handler runs, only a pending source at a strictly higher level can raise `irq_req` again, so handlers nest. Writing the acknowledge register pops the stack when a handler finishes. The register port has separate read and write address paths, so a vector read and an acknowledge can occur in the same cycle. Hardware inputs are level-sensitive and must be synchronous to `clk`.

Top module: `nest_intc`

## Requirements
- R1: After reset every control register reads 0, both `irq_req` and `fiq_req` are low, and a read of the vector register returns 0.
- R2: Control register layout for source i (read address i, write address i): bit 0 enable, bits 2:1 priority level (3 is highest, 0 is lowest), bit 3 software trigger, bit 4 fast-line select. Bits 31:5 are discarded on write and read as zero.
- R3: The vector register sits at address NUM_SRC (128). Among pending normal sources it reports the one at the highest level, and among those the lowest-numbered source. The format is bit 31 valid, bits 17:16 level, bits 6:0 source index, with all other bits zero.
- R4: A source that is enabled and not fast-selected is pending while its hardware input is high or its software trigger bit is set. A disabled source is never pending.
- R5: `irq_req` is high exactly when a source is pending and either no level is active or the best pending level is strictly above the level on top of the active stack.
- R6: Reading the vector register while `irq_req` is high pushes the reported level onto the active stack, which holds up to 4 levels. A read while `irq_req` is low returns 0 and pushes nothing.
- R7: A write to the acknowledge register at address NUM_SRC+1 (129) pops the top level. An acknowledge with an empty stack has no effect.
- R8: When a pushing vector read and an acknowledge fall in the same cycle on a non-empty stack, the top entry is replaced by the new level and the depth does not change.
- R9: `fiq_req` is the OR of the hardware inputs of all sources that are enabled and fast-selected. Such sources never raise `irq_req` and never appear in the vector, and their software trigger bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_src | input | NUM_SRC | Level-sensitive hardware interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | AW | Register write address |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe (a vector read has a side effect) |
| bus_raddr | input | AW | Register read address |
| bus_rdata | output | 32 | Register read data, valid in the cycle of `bus_rd` |
| irq_req | output | 1 | Vectored normal interrupt request |
| fiq_req | output | 1 | Non-vectored fast interrupt request |

## Verification
A vector read, which pushes a level, and an acknowledge write, which pops one, can fall in the same clock edge, because the two strobes use separate address paths. The bench first builds a stack one level deep, raises a higher-level source, and then asserts both strobes in one cycle. It judges the result from the ports alone. After the higher source is withdrawn, `irq_req` must stay low, because the new level is on top. A single acknowledge must then empty the stack, which shows that the depth stayed at one. A wrong ordering of push and pop would leave the old level below the new one, and that would show as `irq_req` low after the acknowledge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // Control register field positions
  localparam int CTL_EN   = 0;
  localparam int CTL_PLO  = 1;
  localparam int CTL_SOFT = 3;
  localparam int CTL_FAST = 4;
  localparam int CTL_W    = 5;
  // Priority level encoding
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  // Vector word fields
  localparam int VEC_VALID = 31;
  localparam int VEC_LVL   = 16;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/nic_rst_sync.sv
module nic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/nic_src_bank.sv
module nic_src_bank
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int AW      = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            waddr,
  input  logic [CTL_W-1:0]         wdata,
  input  logic [AW-1:0]            raddr,
  input  logic [NUM_SRC-1:0]       hw_src,
  output logic [CTL_W-1:0]         ctl_rd,
  output logic [NUM_SRC-1:0]       irq_pend,
  output logic [NUM_SRC*LVL_W-1:0] prio_flat,
  output logic                     fast_req
);
  logic [NUM_SRC*CTL_W-1:0] ctl_flat;
  logic [NUM_SRC-1:0]       fast_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CTL_W-1:0] ctl_q, ctl_d;
    logic             sel;

    assign sel = wr_en && (waddr == AW'(i));

    always_comb begin
      ctl_d = ctl_q;
      if (sel) ctl_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
    end

    assign ctl_flat[i*CTL_W +: CTL_W]  = ctl_q;
    assign prio_flat[i*LVL_W +: LVL_W] = ctl_q[CTL_PLO +: LVL_W];
    assign irq_pend[i] = ctl_q[CTL_EN] && !ctl_q[CTL_FAST] &&
                         (hw_src[i] || ctl_q[CTL_SOFT]);
    assign fast_hit[i] = ctl_q[CTL_EN] && ctl_q[CTL_FAST] && hw_src[i];
  end

  assign fast_req = |fast_hit;

  always_comb begin
    ctl_rd = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raddr == AW'(i)) ctl_rd = ctl_flat[i*CTL_W +: CTL_W];
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int IW      = 7
) (
  input  logic [NUM_SRC-1:0]       irq_pend,
  input  logic [NUM_SRC*LVL_W-1:0] prio_flat,
  output logic                     any_pend,
  output lvl_t                     best_lvl,
  output logic [IW-1:0]            best_idx
);
  logic [NUM_LVL-1:0] lvl_found;
  logic [IW-1:0]      lvl_idx [NUM_LVL];

  // Lowest-numbered pending source within each level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    always_comb begin
      lvl_found[l] = 1'b0;
      lvl_idx[l]   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (irq_pend[i] && (prio_flat[i*LVL_W +: LVL_W] == LVL_W'(l))) begin
          lvl_found[l] = 1'b1;
          lvl_idx[l]   = IW'(i);
        end
      end
    end
  end

  // Highest level with any pending source
  always_comb begin
    any_pend = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_found[l]) begin
        any_pend = 1'b1;
        best_lvl = LVL_W'(l);
        best_idx = lvl_idx[l];
      end
    end
  end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t push_lvl,
  output lvl_t top_lvl,
  output logic empty
);
  localparam int CW = $clog2(DEPTH + 1);

  lvl_t          ent_q [DEPTH];
  lvl_t          ent_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) ent_d[k] = ent_q[k];
    cnt_d = cnt_q;
    if (push && pop && (cnt_q != '0)) begin
      ent_d[0] = push_lvl;
    end else if (push && (cnt_q < CW'(DEPTH))) begin
      for (int k = 1; k < DEPTH; k++) ent_d[k] = ent_q[k-1];
      ent_d[0] = push_lvl;
      cnt_d    = cnt_q + 1'b1;
    end else if (pop && (cnt_q != '0)) begin
      for (int k = 0; k < DEPTH - 1; k++) ent_d[k] = ent_q[k+1];
      ent_d[DEPTH-1] = '0;
      cnt_d          = cnt_q - 1'b1;
    end
  end

  assign cnt_en = push || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= ent_d[k];
      cnt_q <= cnt_d;
    end
  end

  assign top_lvl = ent_q[0];
  assign empty   = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CW'(DEPTH))); // R6
  AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && (cnt_q != '0)) |=> (ent_q[0] > $past(ent_q[0]))); // R6
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (cnt_q == '0)) |=> (cnt_q == '0)); // R7
  AST_SWAP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q))); // R8
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int DEPTH   = 4,
  parameter int AW      = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_src,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_waddr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_raddr,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic               fiq_req
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [AW-1:0] VEC_ADDR = AW'(NUM_SRC);
  localparam logic [AW-1:0] ACK_ADDR = AW'(NUM_SRC + 1);

  logic                     rst_i_n;
  logic [CTL_W-1:0]         ctl_rd;
  logic [NUM_SRC-1:0]       irq_pend;
  logic [NUM_SRC*LVL_W-1:0] prio_flat;
  logic                     any_pend;
  lvl_t                     best_lvl;
  logic [IW-1:0]            best_idx;
  lvl_t                     top_lvl;
  logic                     stk_empty;
  logic                     push, pop;
  logic [31:0]              vec_word;

  nic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  nic_src_bank #(.NUM_SRC(NUM_SRC), .AW(AW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (bus_wr),
    .waddr     (bus_waddr),
    .wdata     (bus_wdata[CTL_W-1:0]),
    .raddr     (bus_raddr),
    .hw_src    (hw_src),
    .ctl_rd    (ctl_rd),
    .irq_pend  (irq_pend),
    .prio_flat (prio_flat),
    .fast_req  (fiq_req)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
    .irq_pend  (irq_pend),
    .prio_flat (prio_flat),
    .any_pend  (any_pend),
    .best_lvl  (best_lvl),
    .best_idx  (best_idx)
  );

  assign irq_req = any_pend && (stk_empty || (best_lvl > top_lvl));
  assign push    = bus_rd && (bus_raddr == VEC_ADDR) && irq_req;
  assign pop     = bus_wr && (bus_waddr == ACK_ADDR);

  nic_level_stack #(.DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .push     (push),
    .pop      (pop),
    .push_lvl (best_lvl),
    .top_lvl  (top_lvl),
    .empty    (stk_empty)
  );

  always_comb begin
    vec_word = '0;
    if (irq_req) begin
      vec_word[VEC_VALID]            = 1'b1;
      vec_word[VEC_LVL +: LVL_W]     = best_lvl;
      vec_word[IW-1:0]               = best_idx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_raddr < VEC_ADDR)       bus_rdata = 32'(ctl_rd);
      else if (bus_raddr == VEC_ADDR) bus_rdata = vec_word;
    end
  end

  AST_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_i_n)
    any_pend |-> (irq_pend[best_idx] &&
                  (prio_flat[best_idx*LVL_W +: LVL_W] == best_lvl))); // R3
endmodule

// File: tb/nest_intc_tb.sv
module nest_intc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 128;
  localparam int AW   = 8;
  localparam logic [AW-1:0] VEC = 8'd128;
  localparam logic [AW-1:0] ACK = 8'd129;
  localparam int NT = 18;

  // {rd, addr[7:0], data[31:0], exp_irq, exp_fiq}; for reads data is the expected rdata
  localparam logic [42:0] TBL [NT] = '{
    {1'b0, 8'd5,  32'h0000000B, 1'b1, 1'b0},  // R4 soft, lvl1
    {1'b0, 8'd9,  32'h0000000B, 1'b1, 1'b0},  // R4
    {1'b1, VEC,   32'h80010005, 1'b0, 1'b0},  // R3 lowest index wins
    {1'b0, 8'd20, 32'h0000000F, 1'b1, 1'b0},  // R5 preempt
    {1'b1, VEC,   32'h80030014, 1'b0, 1'b0},  // R3 higher level wins
    {1'b0, ACK,   32'h00000000, 1'b1, 1'b0},  // R7 pop to lvl1
    {1'b0, 8'd20, 32'h00000007, 1'b0, 1'b0},  // R5 equal level no irq
    {1'b1, VEC,   32'h00000000, 1'b0, 1'b0},  // R6 read w/o irq
    {1'b0, ACK,   32'h00000000, 1'b1, 1'b0},  // R7 empty
    {1'b1, VEC,   32'h80010005, 1'b0, 1'b0},  // R6
    {1'b0, 8'd5,  32'h00000003, 1'b0, 1'b0},  // R4 soft cleared
    {1'b0, ACK,   32'h00000000, 1'b1, 1'b0},  // R7
    {1'b1, VEC,   32'h80010009, 1'b0, 1'b0},  // R3
    {1'b0, 8'd9,  32'h0000000A, 1'b0, 1'b0},  // R4 disabled
    {1'b0, ACK,   32'h00000000, 1'b0, 1'b0},  // R7
    {1'b0, ACK,   32'h00000000, 1'b0, 1'b0},  // R7 ack on empty
    {1'b0, 8'd7,  32'hFFFFFFFF, 1'b0, 1'b0},  // R9 fast, hw low
    {1'b1, 8'd7,  32'h0000001F, 1'b0, 1'b0}   // R2 reserved read zero
  };

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] hw_src;
  logic            bus_wr, bus_rd;
  logic [AW-1:0]   bus_waddr, bus_raddr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic            irq_req, fiq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  nest_intc u_dut (
    .clk(clk), .rst_n(rst_n), .hw_src(hw_src),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_raddr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; hw_src = '0;
    bus_wr = 1'b0; bus_rd = 1'b0;
    bus_waddr = '0; bus_raddr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    check("R1 irq", 32'(irq_req), 32'd0);
    check("R1 fiq", 32'(fiq_req), 32'd0);
    rd(8'd0, d);   check("R1 ctl0", d, 32'd0);
    rd(8'd127, d); check("R1 ctl127", d, 32'd0);
    rd(VEC, d);    check("R1 vec", d, 32'd0);

    // Table walk
    for (int t = 0; t < NT; t++) begin
      if (TBL[t][42]) begin
        rd(TBL[t][41:34], d);
        check("R2/R3/R6 table rdata", d, TBL[t][33:2]);
      end else begin
        wr(TBL[t][41:34], TBL[t][33:2]);
      end
      check("R5/R7 table irq", 32'(irq_req), 32'(TBL[t][1]));
      check("R9 table fiq",    32'(fiq_req), 32'(TBL[t][0]));
    end

    // R9 fast source via hardware; soft bit set has no effect
    @(negedge clk); hw_src[7] = 1'b1; #1;
    check("R9 fiq high", 32'(fiq_req), 32'd1);
    check("R9 no irq", 32'(irq_req), 32'd0);
    rd(VEC, d); check("R9 no vector", d, 32'd0);
    @(negedge clk); hw_src[7] = 1'b0; #1;
    check("R9 fiq low", 32'(fiq_req), 32'd0);

    // R4 level-sensitive hardware source
    wr(8'd100, 32'h5);
    check("R4 hw low", 32'(irq_req), 32'd0);
    @(negedge clk); hw_src[100] = 1'b1; #1;
    check("R4 hw high", 32'(irq_req), 32'd1);
    rd(VEC, d); check("R3 hw vec", d, 32'h80020064);
    check("R6 irq after push", 32'(irq_req), 32'd0);
    @(negedge clk); hw_src[100] = 1'b0; #1;
    wr(ACK, 32'h0);
    check("R4 hw dropped", 32'(irq_req), 32'd0);

    // R6 full-depth nesting
    wr(8'd40, 32'h9);  rd(VEC, d); check("R6 nest0", d, 32'h80000028);
    wr(8'd41, 32'hB);  rd(VEC, d); check("R6 nest1", d, 32'h80010029);
    wr(8'd42, 32'hD);  rd(VEC, d); check("R6 nest2", d, 32'h8002002A);
    wr(8'd43, 32'hF);  rd(VEC, d); check("R6 nest3", d, 32'h8003002B);
    check("R5 full stack", 32'(irq_req), 32'd0);
    wr(ACK, 32'h0);
    check("R7 pop to 2", 32'(irq_req), 32'd1);
    rd(VEC, d); check("R6 repush", d, 32'h8003002B);
    repeat (4) wr(ACK, 32'h0);
    check("R7 drained", 32'(irq_req), 32'd1);
    for (int s = 40; s < 44; s++) wr(AW'(s), 32'h0);
    check("R4 cleared", 32'(irq_req), 32'd0);

    // R8 simultaneous push and pop
    wr(8'd60, 32'hB); rd(VEC, d); check("R8 setup", d, 32'h8001003C);
    wr(8'd61, 32'hD);
    check("R5 preempt", 32'(irq_req), 32'd1);
    @(negedge clk);
    bus_rd = 1'b1; bus_raddr = VEC;
    bus_wr = 1'b1; bus_waddr = ACK; bus_wdata = '0;
    #1 check("R8 vec", bus_rdata, 32'h8002003D);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    #1;
    wr(8'd61, 32'h0);
    check("R8 top replaced", 32'(irq_req), 32'd0);
    wr(ACK, 32'h0);
    check("R8 depth one", 32'(irq_req), 32'd1);
    wr(8'd60, 32'h0);
    check("R8 clean", 32'(irq_req), 32'd0);

    finish_run();
  end
endmodule